// File: doc/BRIEF.md
# APB Register Slave with Programmable Wait States

This block is the peripheral side of an APB bus that fronts a small bank of 32-bit control registers. A host bridge drives select, enable, direction, address and write data. The block answers with ready, read data and an error flag. Every access phase is stretched by a programmable number of wait cycles, so the same block can stand in for a slow peripheral or run at the bus's minimum two-cycle rate.

The wait count lives in a register in the bank, and the host can write it like any other register. A new count takes effect from the next transfer. The error flag is raised for any access to a word that is not mapped. It is also raised for a write to the identification word, which is read-only; that word keeps its value. Writes reach storage only in the cycle that completes the transfer, never while ready is held low.

Back-pressure rules: ready is the only flow control. While select and enable are both high and ready is low, the host holds address, direction and write data steady. The transfer ends in the first access cycle that sees ready high. Outside the access phase ready is driven high, and its value there carries no meaning.

Top module: `pbus_regslave`

## Requirements
- R1: After reset, ready is high and error is low. The wait register and every read/write register read back as zero, and the first transfer completes without wait cycles.
- R2: The word index is address bits [7:2], and address bits [1:0] are ignored. Index 0 is the wait register. Indices 1 to 4 are read/write registers. Index 5 is a read-only identification word with value 0x5A170C3E. Indices 6 to 63 are unmapped.
- R3: With a wait count of N (0 to 15), ready stays low for the first N access-phase cycles and rises in cycle N+1.
- R4: A write to the wait register completes with the old count. The new count applies from the next transfer.
- R5: The wait register stores the low 4 bits of the write data. Bits [31:4] read as zero.
- R6: Each read/write register stores a full 32-bit value and returns it on a read.
- R7: A write to the identification word completes with error high and leaves the word unchanged.
- R8: A read or write to an unmapped index completes with error high and changes no register.
- R9: Error is low in every cycle except a completing access cycle, which is one where select, enable and ready are all high.
- R10: Register contents change only on the completing cycle of a write. Stalled access cycles leave them unchanged.
- R11: Ready is high in every cycle in which select and enable are not both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Slave selected |
| penable | input | 1 | Second and later cycles of a transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| pready | output | 1 | Transfer completes this cycle when high in access phase |
| prdata | output | 32 | Read data, valid on the completing read cycle |
| pslverr | output | 1 | Error response on the completing cycle |

## Verification
A wrong wait counter shows at the ports in the very next transfer: ready rises a cycle too early or too late, or never. A count that leaks between transfers shifts the stall length of the following access. A decode fault shows on the completing cycle of the affected access, as a missing or spurious error. A write that lands on a stalled cycle, or that reaches a read-only or unmapped word, only shows on a later read-back. For that reason every fault case is followed by a sweep that reads the whole bank back.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    KIND_RW   = 2'd0,
    KIND_RO   = 2'd1,
    KIND_NONE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/pbus_waitgen.sv
module pbus_waitgen #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              access,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              done
);
  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic              busy;
  logic [WAIT_W-1:0] cnt;

  // First access cycle compares the configured count; later cycles the counter.
  always_comb done = busy ? (cnt == '0) : (wait_cfg == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!access || done) begin
      busy <= 1'b0;
    end else if (!busy) begin
      busy <= 1'b1;
      cnt  <= wait_cfg - ONE;
    end else begin
      cnt  <= cnt - ONE;
    end
  end
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
  import pbus_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NUM_RW = 4,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] paddr,
  output logic [IDX_W-1:0]  idx,
  output acc_kind_e         kind
);
  localparam logic [IDX_W-1:0] LAST_RW = IDX_W'(NUM_RW);
  localparam logic [IDX_W-1:0] ID_IDX  = IDX_W'(NUM_RW + 1);

  assign idx = paddr[ADDR_W-1:2];

  always_comb begin
    if (idx <= LAST_RW)     kind = KIND_RW;
    else if (idx == ID_IDX) kind = KIND_RO;
    else                    kind = KIND_NONE;
  end
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile
  import pbus_pkg::*;
#(
  parameter int          IDX_W    = 6,
  parameter int          NUM_RW   = 4,
  parameter int          WAIT_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h5A170C3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val,
  output logic [WAIT_W-1:0] wait_cfg
);
  localparam logic [IDX_W-1:0] ID_IDX = IDX_W'(NUM_RW + 1);

  logic [DATA_W-1:0] gp [NUM_RW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   wait_cfg <= '0;
    else if (wr_en && idx == '0)  wait_cfg <= wdata[WAIT_W-1:0];
  end

  for (genvar g = 0; g < NUM_RW; g++) begin : g_gp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               gp[g] <= '0;
      else if (wr_en && idx == IDX_W'(g + 1))   gp[g] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (idx == '0)          rd_val = {{(DATA_W-WAIT_W){1'b0}}, wait_cfg};
    else if (idx == ID_IDX) rd_val = ID_VALUE;
    for (int i = 0; i < NUM_RW; i++)
      if (idx == IDX_W'(i + 1)) rd_val = gp[i];
  end
endmodule

// File: rtl/pbus_regslave.sv
module pbus_regslave
  import pbus_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          NUM_RW   = 4,
  parameter int          WAIT_W   = 4,
  parameter logic [31:0] ID_VALUE = 32'h5A170C3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic              pready,
  output logic [31:0]       prdata,
  output logic              pslverr
);
  localparam int IDX_W = ADDR_W - 2;

  logic              access;
  logic              done;
  logic              fault;
  logic              wr_en;
  logic [IDX_W-1:0]  idx;
  acc_kind_e         kind;
  logic [WAIT_W-1:0] wait_cfg;
  logic [31:0]       rd_val;

  assign access = psel & penable;

  pbus_decode #(.ADDR_W(ADDR_W), .NUM_RW(NUM_RW)) u_dec (
    .paddr (paddr),
    .idx   (idx),
    .kind  (kind)
  );

  pbus_waitgen #(.WAIT_W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .access   (access),
    .wait_cfg (wait_cfg),
    .done     (done)
  );

  assign fault = (kind == KIND_NONE) | (pwrite & (kind == KIND_RO));
  assign wr_en = access & done & pwrite & ~fault;

  pbus_regfile #(
    .IDX_W(IDX_W), .NUM_RW(NUM_RW), .WAIT_W(WAIT_W), .ID_VALUE(ID_VALUE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .idx      (idx),
    .wdata    (pwdata),
    .rd_val   (rd_val),
    .wait_cfg (wait_cfg)
  );

  assign pready  = access ? done : 1'b1;
  assign pslverr = access & done & fault;
  assign prdata  = (access & ~pwrite) ? rd_val : '0;
endmodule

// File: rtl/pbus_regslave_chk.sv
module pbus_regslave_chk #(
  parameter int ADDR_W = 8,
  parameter int NUM_RW = 4,
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              pready,
  input logic              pslverr,
  input logic [WAIT_W-1:0] wait_cfg
);
  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W-1:0] ID_IDX = IDX_W'(NUM_RW + 1);

  logic              acc;
  logic [IDX_W-1:0]  cidx;
  logic [WAIT_W:0]   stall_cnt;
  logic [WAIT_W-1:0] cfg_lat;

  assign acc  = psel & penable;
  assign cidx = paddr[ADDR_W-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_cnt <= '0;
      cfg_lat   <= '0;
    end else if (psel && !penable) begin
      stall_cnt <= '0;
      cfg_lat   <= wait_cfg;
    end else if (acc && !pready) begin
      stall_cnt <= stall_cnt + 1'b1;
    end
  end

  // R9
  err_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pready) |-> !pslverr);

  // R11
  ready_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable) |-> pready);

  // R3
  stall_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pready) |-> (stall_cnt == {1'b0, cfg_lat}));

  // R10
  stall_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !pready) |=> $stable(wait_cfg));

  // R7
  ro_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pready && pwrite && cidx == ID_IDX) |-> pslverr);

  // R8
  unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pready && cidx > ID_IDX) |-> pslverr);
endmodule

bind pbus_regslave pbus_regslave_chk #(
  .ADDR_W(ADDR_W), .NUM_RW(NUM_RW), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pready(pready), .pslverr(pslverr), .wait_cfg(wait_cfg)
);

// File: tb/pbus_regslave_test.sv
`timescale 1ns/1ps
module pbus_regslave_test;
  localparam logic [31:0] ID_VAL = 32'h5A170C3E;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic        pready, pslverr;
  logic [31:0] prdata;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_gp [1:4];
  logic [3:0]  exp_wait;

  always #2 clk = ~clk;

  pbus_regslave uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [5:0] idx, input logic [1:0] lo,
                      input logic [31:0] wd, output logic [31:0] rd,
                      output logic e, output int waits);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = {idx, lo}; pwdata = wd;
    #1 chk("R11 ready in setup", {31'b0, pready}, 32'd1);
    @(negedge clk); penable = 1'b1; waits = 0;
    forever begin
      #1;
      if (pready) break;
      chk("R9 err low while stalled", {31'b0, pslverr}, 32'd0);
      waits++;
      if (waits > 40) break;
      @(negedge clk);
    end
    rd = prdata; e = pslverr;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] idx, input logic [31:0] exp,
                        input logic exp_e, input int exp_w);
    logic [31:0] d; logic e; int w;
    xfer(1'b0, idx, 2'b00, 32'h0, d, e, w);
    if (!exp_e) chk({req, " data"}, d, exp);
    chk({req, " err"}, {31'b0, e}, {31'b0, exp_e});
    chk({req, " waits"}, w, exp_w);
  endtask

  task automatic wr_chk(input string req, input logic [5:0] idx, input logic [1:0] lo,
                        input logic [31:0] v, input logic exp_e, input int exp_w);
    logic [31:0] d; logic e; int w;
    xfer(1'b1, idx, lo, v, d, e, w);
    chk({req, " err"}, {31'b0, e}, {31'b0, exp_e});
    chk({req, " waits"}, w, exp_w);
  endtask

  task automatic bank_chk(input string req);
    rd_chk({req, " wait reg"}, 6'd0, {28'b0, exp_wait}, 1'b0, int'(exp_wait));
    for (int i = 1; i <= 4; i++)
      rd_chk({req, " rw reg"}, 6'(i), exp_gp[i], 1'b0, int'(exp_wait));
    rd_chk({req, " id"}, 6'd5, ID_VAL, 1'b0, int'(exp_wait));
  endtask

  initial begin
    #800000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int prev;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'b0, pready}, 32'd1);
    chk("R1 reset err", {31'b0, pslverr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle ready", {31'b0, pready}, 32'd1);
    exp_wait = 4'd0;
    for (int i = 1; i <= 4; i++) exp_gp[i] = '0;
    bank_chk("R1 reset bank");

    // R6: full-width storage, two complementary patterns
    for (int i = 1; i <= 4; i++) begin
      v = 32'hA5C3_0F69 ^ (32'h0101_0101 * i);
      wr_chk("R6 write", 6'(i), 2'b00, v, 1'b0, 0); exp_gp[i] = v;
    end
    bank_chk("R6 readback");
    for (int i = 1; i <= 4; i++) begin
      wr_chk("R6 write inv", 6'(i), 2'b00, ~exp_gp[i], 1'b0, 0); exp_gp[i] = ~exp_gp[i];
    end
    bank_chk("R6 readback inv");

    // R2: low address bits ignored
    wr_chk("R2 offset bits", 6'd2, 2'b11, 32'h1234_5678, 1'b0, 0); exp_gp[2] = 32'h1234_5678;
    rd_chk("R2 offset alias", 6'd2, 32'h1234_5678, 1'b0, 0);

    // R5: only low 4 bits kept
    wr_chk("R5 wide write", 6'd0, 2'b00, 32'hFFFF_FFF3, 1'b0, 0); exp_wait = 4'd3;
    rd_chk("R5 masked read", 6'd0, 32'd3, 1'b0, 3);
    wr_chk("R5 clear", 6'd0, 2'b00, 32'd0, 1'b0, 3); exp_wait = 4'd0;

    // R3/R4/R10: sweep every wait count
    prev = 0;
    for (int w = 0; w < 16; w++) begin
      wr_chk("R4 old count on cfg write", 6'd0, 2'b00, 32'(w), 1'b0, prev);
      exp_wait = 4'(w);
      rd_chk("R3 read stall", 6'd0, 32'(w), 1'b0, w);
      v = 32'hC0DE_0000 | 32'(w * 17);
      wr_chk("R3 write stall", 6'd1, 2'b00, v, 1'b0, w); exp_gp[1] = v;
      rd_chk("R10 stalled write value", 6'd1, v, 1'b0, w);
      prev = w;
    end

    wr_chk("R3 set two", 6'd0, 2'b00, 32'd2, 1'b0, 15); exp_wait = 4'd2;
    // R7: read-only identification word
    wr_chk("R7 ro write", 6'd5, 2'b00, 32'hDEAD_BEEF, 1'b1, 2);
    rd_chk("R7 id intact", 6'd5, ID_VAL, 1'b0, 2);

    // R8: every unmapped index, both directions
    for (int k = 6; k < 64; k++) begin
      rd_chk("R8 unmapped read", 6'(k), 32'h0, 1'b1, 2);
      wr_chk("R8 unmapped write", 6'(k), 2'b00, 32'hFFFF_FFFF, 1'b1, 2);
    end
    bank_chk("R8 bank intact");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule